// File: doc/BRIEF.md
# Sequential-Address Bus Coder

This block cuts switching on an address bus whose traffic is mostly in ascending runs. One encoder sits at the sending end and one decoder at the receiving end. A single extra wire, the step flag, travels beside the address wires. When a new address is exactly the last sent address plus a fixed stride, the encoder raises the step flag and leaves every address wire where it was. The decoder then adds the stride to its own last output to rebuild the address. Any other address goes out in full with the flag low.

The top module joins the encoder and the decoder so that the coded link can be seen at its ports. The coded address, the step flag and a word-valid strobe are outputs registered by the encoder. The decoder registers the rebuilt address one cycle after that. The address width and the stride are parameters, 32 bits and 1 by default. All arithmetic wraps modulo 2^AW. Reset is synchronous and active high.

Top module: `seqbus_link`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `bus_o`, `inc_o`, `bus_vld_o`, `out_vld` and `out_addr` are all zero.
- R2: The first valid input after reset is always sent in full: `inc_o` = 0 and `bus_o` = that address. This holds even when the address equals 0 + STRIDE.
- R3: When a valid input equals the previous valid input plus STRIDE, the next cycle shows `inc_o` = 1 and `bus_vld_o` = 1, and `bus_o` is unchanged.
- R4: When a valid input is not the previous valid input plus STRIDE, the next cycle shows `inc_o` = 0 and `bus_o` = the input address. A repeated address counts as a mismatch.
- R5: The stride sum wraps modulo 2^AW. With STRIDE = 1, the address all-ones followed by address 0 is sent as a step word.
- R6: Every valid input address appears on `out_addr`, with `out_vld` = 1, two cycles after it is presented. That is one cycle after its coded word shows `bus_vld_o` = 1.
- R7: A cycle with `in_vld` = 0 makes `bus_vld_o` = 0 in the next cycle and leaves `bus_o` and `inc_o` unchanged. It also leaves the stored previous address untouched, so a run may continue across idle cycles.
- R8: A cycle with `bus_vld_o` = 0 makes `out_vld` = 0 in the next cycle and leaves `out_addr` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Input address is valid this cycle |
| in_addr | input | AW | Address to send |
| bus_o | output | AW | Coded address wires |
| inc_o | output | 1 | Step flag: the receiver adds STRIDE to its last address |
| bus_vld_o | output | 1 | Coded word valid |
| out_vld | output | 1 | Rebuilt address valid |
| out_addr | output | AW | Rebuilt address at the receiver |

## Verification
The assertions check on every cycle that step words leave the address wires still, and that full words carry the input address. They also check that idle cycles freeze the coded bus and the receiver, that the first word after reset is never a step, and that every accepted address returns at the receiver two cycles later. Some cases need a chosen sequence of inputs to show up, and only the bench's scenarios exercise them. These are the stride wrap at all-ones, a run continuing across idle gaps, repeated addresses, and a second reset in the middle of a run that resets the stored address on both sides.

// File: rtl/seqbus_pkg.sv
package seqbus_pkg;

  // Meaning of the step flag on the coded link.
  typedef enum logic {
    WORD_FULL = 1'b0,
    WORD_STEP = 1'b1
  } word_kind_e;

  // A word is a step only once a reference address exists and the stride sum matches.
  function automatic word_kind_e classify(input logic primed, input logic stride_match);
    return (primed && stride_match) ? WORD_STEP : WORD_FULL;
  endfunction

endpackage

// File: rtl/seqbus_enc.sv
module seqbus_enc
  import seqbus_pkg::*;
#(
  parameter int AW     = 32,
  parameter int STRIDE = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_vld,
  input  logic [AW-1:0] in_addr,
  output logic [AW-1:0] bus_q,
  output logic          inc_q,
  output logic          bus_vld_q,
  output logic          hit_o
);

  // Stride sum, wrapping modulo 2^AW.
  function automatic logic [AW-1:0] run_next(input logic [AW-1:0] a);
    return a + AW'(STRIDE);
  endfunction

  logic [AW-1:0] prev_q;
  logic          primed_q;
  word_kind_e    kind;

  always_comb begin
    kind  = classify(primed_q, in_addr == run_next(prev_q));
    hit_o = in_vld && (kind == WORD_STEP);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q    <= '0;
      primed_q  <= 1'b0;
      bus_q     <= '0;
      inc_q     <= 1'b0;
      bus_vld_q <= 1'b0;
    end else begin
      bus_vld_q <= in_vld;
      if (in_vld) begin
        prev_q   <= in_addr;
        primed_q <= 1'b1;
        inc_q    <= (kind == WORD_STEP);
        if (kind == WORD_FULL) begin
          bus_q <= in_addr;
        end
      end
    end
  end

endmodule

// File: rtl/seqbus_dec.sv
module seqbus_dec #(
  parameter int AW     = 32,
  parameter int STRIDE = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_vld,
  input  logic [AW-1:0] bus,
  input  logic          inc,
  output logic          out_vld,
  output logic [AW-1:0] out_addr
);

  function automatic logic [AW-1:0] run_next(input logic [AW-1:0] a);
    return a + AW'(STRIDE);
  endfunction

  logic [AW-1:0] regen;
  logic [AW-1:0] pick;

  // Two-way select between the rebuilt step address and the wires.
  always_comb begin
    regen = run_next(out_addr);
    pick  = inc ? regen : bus;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_addr <= '0;
      out_vld  <= 1'b0;
    end else begin
      out_vld <= bus_vld;
      if (bus_vld) begin
        out_addr <= pick;
      end
    end
  end

endmodule

// File: rtl/seqbus_link.sv
module seqbus_link #(
  parameter int AW     = 32,
  parameter int STRIDE = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_vld,
  input  logic [AW-1:0] in_addr,
  output logic [AW-1:0] bus_o,
  output logic          inc_o,
  output logic          bus_vld_o,
  output logic          out_vld,
  output logic [AW-1:0] out_addr
);

  // Encoder decision this cycle, brought out for the checker.
  logic enc_hit;

  seqbus_enc #(.AW(AW), .STRIDE(STRIDE)) u_enc (
    .clk      (clk),
    .rst      (rst),
    .in_vld   (in_vld),
    .in_addr  (in_addr),
    .bus_q    (bus_o),
    .inc_q    (inc_o),
    .bus_vld_q(bus_vld_o),
    .hit_o    (enc_hit)
  );

  seqbus_dec #(.AW(AW), .STRIDE(STRIDE)) u_dec (
    .clk     (clk),
    .rst     (rst),
    .bus_vld (bus_vld_o),
    .bus     (bus_o),
    .inc     (inc_o),
    .out_vld (out_vld),
    .out_addr(out_addr)
  );

endmodule

// File: rtl/seqbus_link_chk.sv
module seqbus_link_chk #(
  parameter int AW     = 32,
  parameter int STRIDE = 1
) (
  input logic          clk,
  input logic          rst,
  input logic          in_vld,
  input logic [AW-1:0] in_addr,
  input logic [AW-1:0] bus_o,
  input logic          inc_o,
  input logic          bus_vld_o,
  input logic          out_vld,
  input logic [AW-1:0] out_addr,
  input logic          enc_hit
);

  // Checker-side history: any valid since reset, and the last valid address.
  logic          seen_q;
  logic [AW-1:0] last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q <= 1'b0;
      last_q <= '0;
    end else if (in_vld) begin
      seen_q <= 1'b1;
      last_q <= in_addr;
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (bus_o == '0 && !inc_o && !bus_vld_o && !out_vld && out_addr == '0));

  p_first_full_r2: assert property (@(posedge clk) disable iff (rst)
    (in_vld && !seen_q) |=> (!inc_o && bus_o == $past(in_addr)));

  p_step_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (in_vld && enc_hit) |=> (inc_o && bus_vld_o && $stable(bus_o)));

  p_full_send_r4: assert property (@(posedge clk) disable iff (rst)
    (in_vld && !enc_hit) |=> (!inc_o && bus_vld_o && bus_o == $past(in_addr)));

  p_wrap_step_r5: assert property (@(posedge clk) disable iff (rst)
    (in_vld && seen_q && last_q == '1 && in_addr == AW'(STRIDE - 1)) |-> enc_hit);

  p_roundtrip_r6: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> ##1 (out_vld && out_addr == $past(in_addr, 2)));

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> (!bus_vld_o && $stable(bus_o) && $stable(inc_o)));

  p_dec_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !bus_vld_o |=> (!out_vld && $stable(out_addr)));

endmodule

bind seqbus_link seqbus_link_chk #(.AW(AW), .STRIDE(STRIDE)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_vld   (in_vld),
  .in_addr  (in_addr),
  .bus_o    (bus_o),
  .inc_o    (inc_o),
  .bus_vld_o(bus_vld_o),
  .out_vld  (out_vld),
  .out_addr (out_addr),
  .enc_hit  (enc_hit)
);

// File: tb/seqbus_link_test.sv
module seqbus_link_test;

  localparam int AW     = 32;
  localparam int STRIDE = 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_vld = 1'b0;
  logic [AW-1:0] in_addr = '0;
  logic [AW-1:0] bus_o;
  logic          inc_o;
  logic          bus_vld_o;
  logic          out_vld;
  logic [AW-1:0] out_addr;

  int    vectors = 0;
  int    errors  = 0;
  string tag     = "R1";

  always #5 clk = ~clk;

  seqbus_link #(.AW(AW), .STRIDE(STRIDE)) uut (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_addr(in_addr),
    .bus_o(bus_o), .inc_o(inc_o), .bus_vld_o(bus_vld_o),
    .out_vld(out_vld), .out_addr(out_addr)
  );

  // Behavioural reference: sender state plus a delay queue of offered inputs.
  logic [AW-1:0] m_prev = '0, m_bus = '0, m_out = '0;
  logic          m_started = 1'b0, m_inc = 1'b0, m_bvld = 1'b0, m_ovld = 1'b0;
  logic [AW:0]   hist[$];

  always @(posedge clk) begin
    logic [AW:0]   h;
    logic [63:0]   wide;
    logic [AW-1:0] follow;
    if (rst) begin
      m_prev = '0; m_bus = '0; m_out = '0;
      m_started = 1'b0; m_inc = 1'b0; m_bvld = 1'b0; m_ovld = 1'b0;
      hist.delete();
    end else begin
      // Receiver: returns what was offered one edge earlier (R6, R8).
      m_ovld = 1'b0;
      if (hist.size() > 0) begin
        h = hist.pop_front();
        if (h[AW]) begin
          m_out  = h[AW-1:0];
          m_ovld = 1'b1;
        end
      end
      hist.push_back({in_vld, in_addr});
      // Sender (R2, R3, R4, R5, R7).
      m_bvld = in_vld;
      if (in_vld) begin
        wide   = (64'(m_prev) + 64'(STRIDE)) % (64'd1 << AW);
        follow = wide[AW-1:0];
        if (m_started && in_addr == follow) begin
          m_inc = 1'b1;
        end else begin
          m_inc = 1'b0;
          m_bus = in_addr;
        end
        m_prev    = in_addr;
        m_started = 1'b1;
      end
    end
  end

  task automatic check_now();
    vectors++;
    if (bus_o !== m_bus || inc_o !== m_inc || bus_vld_o !== m_bvld ||
        out_vld !== m_ovld || out_addr !== m_out) begin
      errors++;
      $display("FAIL %s: got bus=%h inc=%b bvld=%b ovld=%b out=%h, expected bus=%h inc=%b bvld=%b ovld=%b out=%h",
               tag, bus_o, inc_o, bus_vld_o, out_vld, out_addr,
               m_bus, m_inc, m_bvld, m_ovld, m_out);
    end
  endtask

  task automatic apply(input logic v, input logic [AW-1:0] a);
    in_vld  = v;
    in_addr = a;
    @(negedge clk);
    check_now();
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got no finish, expected end of run");
    report();
    $finish;
  end

  initial begin
    // R1: outputs quiet under reset and just after it.
    tag = "R1";
    repeat (2) @(negedge clk);
    check_now();
    rst = 1'b0;
    apply(1'b0, '0);

    // R2: address 1 equals 0 + STRIDE but is the first word, so it goes in full.
    tag = "R2";
    apply(1'b1, 32'h1);
    // R3: a run leaves the wires still.
    tag = "R3";
    for (int i = 2; i < 9; i++) apply(1'b1, AW'(i));

    // R4: jumps, a repeated address, a backward step.
    tag = "R4";
    apply(1'b1, 32'h0000_0100);
    apply(1'b1, 32'h0000_0040);
    apply(1'b1, 32'h0000_0040);
    apply(1'b1, 32'h0000_003F);
    apply(1'b1, 32'hA5A5_0000);

    // R7: idle cycles carry junk and must not disturb the stored address.
    tag = "R7";
    apply(1'b1, 32'h0000_0500);
    apply(1'b0, 32'hDEAD_BEEF);
    apply(1'b0, 32'h0000_0501);
    apply(1'b1, 32'h0000_0501);
    apply(1'b0, 32'h1234_5678);
    apply(1'b1, 32'h0000_0502);

    // R5: wrap at all-ones.
    tag = "R5";
    apply(1'b1, 32'hFFFF_FFFE);
    apply(1'b1, 32'hFFFF_FFFF);
    apply(1'b1, 32'h0000_0000);
    apply(1'b1, 32'h0000_0001);

    // R6: mixed runs, jumps and gaps.
    tag = "R6";
    for (int i = 0; i < 24; i++) begin
      if (i % 7 == 3) apply(1'b0, AW'(i * 3));
      else if (i % 5 == 4) apply(1'b1, AW'(32'h8000_0000 + i * 16));
      else apply(1'b1, AW'(32'h0000_1000 + i));
    end

    // R8: a quiet stretch; the receiver holds its last address.
    tag = "R8";
    for (int i = 0; i < 4; i++) apply(1'b0, AW'(i));

    // R1 again: reset mid-run clears both ends.
    tag = "R1";
    apply(1'b1, 32'h0000_2000);
    rst = 1'b1;
    apply(1'b1, 32'h0000_2001);
    apply(1'b0, '0);
    rst = 1'b0;
    apply(1'b0, '0);

    // R2 again: first word after the second reset is full, then a run follows.
    tag = "R2";
    apply(1'b1, 32'h0000_0001);
    apply(1'b1, 32'h0000_0002);
    tag = "R6";
    apply(1'b0, '0);
    apply(1'b0, '0);

    report();
    $finish;
  end

endmodule